// File: doc/BRIEF.md
# Two-Stage Product Code Link Receiver

This block sits at the receiving end of an on-chip link protected by a two-dimensional product code. The 32-bit message is laid out as four rows of eight bits. The first transfer carries only the four row codewords: each row is protected by an extended Hamming code of 13 bits, and the four together make a 52-bit link word. The receiver decodes all four rows in parallel. A single error in a row is corrected on the spot, and a double error is flagged.

When no row reports a double error, the receiver delivers the message at once and acknowledges it. When any row reports a double error, the receiver keeps the row data it has, answers with a retransmission request, and waits for the second transfer. The second transfer carries the column check bits: each of the eight columns is an extended Hamming (8,4) codeword, and its four check bits are themselves row-encoded. The receiver first row-decodes that word to recover the 32 column check bits. It then decodes every column together with the held data and delivers the repaired message. If a column is still uncorrectable, the message goes out with an uncorrectable flag. The request is raised again periodically while no second transfer arrives.

Top module: `pc_harq_rx`

## Requirements
- R1: Every 13-bit row codeword uses bit 0 as the overall even parity over all 13 bits. Bits 1, 2, 4 and 8 are Hamming checks, where the check at position 2^b makes even the parity over the positions whose index has bit b set. The eight data bits sit, lowest first, at positions 3, 5, 6, 7, 9, 10, 11 and 12. Row r occupies linkWord[13r+12 : 13r].
- R2: A first-transfer word (linkPhase=0) accepted while idle, with no row carrying more than one error, produces on the next cycle a one-cycle msgValid and ackValid. msgData holds the corrected message and nackValid stays low.
- R3: A first-transfer word with a double error in any row produces a one-cycle nackValid on the next cycle, with msgValid and ackValid low. The receiver then waits for the second transfer.
- R4: The second transfer (linkPhase=1) holds four row codewords laid out as in R1. Row q carries check q of each column, with data bit j belonging to column j. Column j is an 8-bit extended Hamming word with the same layout as R1: overall parity at bit 0, checks at bits 1, 2 and 4, and row 0..3 data bit j at bits 3, 5, 6 and 7. Check q is the column bit at position 0, 1, 2 or 4 for q = 0, 1, 2 or 3.
- R5: A second transfer accepted while waiting produces, on the next cycle, msgValid with the column-corrected message. With it comes ackValid, or msgUncorr instead of ackValid when any column reports a double error.
- R6: Every single error and every double error in the first transfer yields the original message, after the first transfer or, failing that, after the second.
- R7: While waiting, nackValid pulses again every TIMEOUT_CYC cycles (16 by default) counted from the previous pulse, until a second transfer arrives.
- R8: A second-transfer word received while idle, and a first-transfer word received while waiting, have no effect on the outputs or on the held data.
- R9: msgData bit 8r+j is data bit j of row r.
- R10: During and after reset all outputs are low. ackValid and nackValid are never high together, and msgValid is high only in the cycle after a cycle with linkValid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkValid | input | 1 | A link word is present this cycle |
| linkPhase | input | 1 | 0 = row-coded first transfer, 1 = column-check second transfer |
| linkWord | input | 52 | Four 13-bit row codewords |
| msgValid | output | 1 | Delivered message strobe |
| msgData | output | 32 | Delivered message |
| msgUncorr | output | 1 | Delivered message has an uncorrectable column |
| ackValid | output | 1 | Message accepted pulse |
| nackValid | output | 1 | Retransmission request pulse |

## Verification
A sweep over all 52 single-bit error positions for several messages shows that every row corrects independently on the first pass with no request. The full sweep over all 1326 error pairs separates two cases. Pairs split across rows must be delivered directly. Pairs inside one row must raise a request and then be repaired through the columns. Two rows each holding a double error in the same two columns create a column double error, which must come out flagged rather than acknowledged. Timeout spacing is measured between successive requests. Words sent with the wrong phase must leave both the outputs and the held data unchanged.

// File: rtl/pc_harq_pkg.sv
package pc_harq_pkg;

  typedef struct packed {
    logic deliverRows;
    logic captureRows;
    logic deliverCols;
    logic raiseNack;
  } rxStrobes_t;

  typedef enum logic {PH_IDLE, PH_WAIT} rxPhase_t;

  function automatic int parBits(input int k);
    int p;
    p = 0;
    for (int i = 0; i < 16; i++) begin
      if ((1 << p) < k + p + 1) p++;
    end
    return p;
  endfunction

  function automatic bit isPow2(input int i);
    return (i != 0) && ((i & (i - 1)) == 0);
  endfunction

endpackage

// File: rtl/eham_dec.sv
module eham_dec #(
  parameter int DATA_W = 8,
  localparam int PAR_W = pc_harq_pkg::parBits(DATA_W),
  localparam int CODE_W = DATA_W + PAR_W + 1
) (
  input  logic [CODE_W-1:0] codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              ded
);
  import pc_harq_pkg::*;

  logic [CODE_W-1:0] fixedCode;
  logic              oddParity;
  int                syn;

  always_comb begin
    syn = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if (codeIn[i]) syn = syn ^ i;
    end
    oddParity = ^codeIn;
    fixedCode = codeIn;
    if (oddParity && syn < CODE_W) begin
      fixedCode = codeIn ^ ({{(CODE_W-1){1'b0}}, 1'b1} << syn);
    end
    ded = (!oddParity && syn != 0) || (oddParity && syn >= CODE_W);
  end

  always_comb begin
    int k;
    k = 0;
    dataOut = '0;
    for (int i = 1; i < CODE_W; i++) begin
      if (!isPow2(i)) begin
        dataOut[k] = fixedCode[i];
        k++;
      end
    end
  end

endmodule

// File: rtl/pc_harq_ctrl.sv
module pc_harq_ctrl
  import pc_harq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkValid,
  input  logic       linkPhase,
  input  logic       anyRowDed,
  output rxStrobes_t strobes
);

  rxPhase_t          phase;
  logic [CNT_W-1:0]  waitCnt;
  logic              acceptFirst;
  logic              acceptSecond;
  logic              expire;

  always_comb begin
    acceptFirst  = (phase == PH_IDLE) && linkValid && !linkPhase;
    acceptSecond = (phase == PH_WAIT) && linkValid && linkPhase;
    expire       = (phase == PH_WAIT) && !acceptSecond &&
                   (waitCnt == CNT_W'(TIMEOUT_CYC - 1));
    strobes.deliverRows = acceptFirst && !anyRowDed;
    strobes.captureRows = acceptFirst && anyRowDed;
    strobes.deliverCols = acceptSecond;
    strobes.raiseNack   = (acceptFirst && anyRowDed) || expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
    end else if (strobes.captureRows) begin
      phase   <= PH_WAIT;
      waitCnt <= '0;
    end else if (acceptSecond) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
    end else if (phase == PH_WAIT) begin
      waitCnt <= expire ? '0 : waitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pc_harq_dp.sv
module pc_harq_dp
  import pc_harq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int ROW_DATA = 8,
  localparam int ROW_CODE = ROW_DATA + parBits(ROW_DATA) + 1,
  localparam int COL_CODE = ROWS + parBits(ROWS) + 1,
  localparam int MSG_W = ROWS * ROW_DATA,
  localparam int LINK_W = ROWS * ROW_CODE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINK_W-1:0] linkWord,
  input  rxStrobes_t        strobes,
  output logic              anyRowDed,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgData,
  output logic              msgUncorr,
  output logic              ackValid,
  output logic              nackValid
);

  logic [ROW_DATA-1:0] rowData [ROWS];
  logic [ROW_DATA-1:0] heldRow [ROWS];
  logic [ROWS-1:0]     rowDed;
  logic [COL_CODE-1:0] colCode [ROW_DATA];
  logic [ROWS-1:0]     colData [ROW_DATA];
  logic [ROW_DATA-1:0] colDed;
  logic [MSG_W-1:0]    rowMsg;
  logic [MSG_W-1:0]    colMsg;

  for (genvar g = 0; g < ROWS; g++) begin : gRow
    eham_dec #(.DATA_W(ROW_DATA)) uRow (
      .codeIn (linkWord[g*ROW_CODE +: ROW_CODE]),
      .dataOut(rowData[g]),
      .ded    (rowDed[g])
    );
  end

  // Column j: held row data at data positions, check rows (current word) at check positions.
  always_comb begin
    for (int j = 0; j < ROW_DATA; j++) begin
      int r;
      int q;
      r = 0;
      q = 0;
      colCode[j] = '0;
      for (int p = 0; p < COL_CODE; p++) begin
        if (p != 0 && !isPow2(p)) begin
          colCode[j][p] = heldRow[r][j];
          r++;
        end else begin
          colCode[j][p] = rowData[q][j];
          q++;
        end
      end
    end
  end

  for (genvar g = 0; g < ROW_DATA; g++) begin : gCol
    eham_dec #(.DATA_W(ROWS)) uCol (
      .codeIn (colCode[g]),
      .dataOut(colData[g]),
      .ded    (colDed[g])
    );
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < ROW_DATA; j++) begin
        rowMsg[r*ROW_DATA + j] = rowData[r][j];
        colMsg[r*ROW_DATA + j] = colData[j][r];
      end
    end
    anyRowDed = |rowDed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) heldRow[r] <= '0;
    end else if (strobes.captureRows) begin
      for (int r = 0; r < ROWS; r++) heldRow[r] <= rowData[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      msgData   <= '0;
      msgUncorr <= 1'b0;
      ackValid  <= 1'b0;
      nackValid <= 1'b0;
    end else begin
      msgValid  <= strobes.deliverRows || strobes.deliverCols;
      msgUncorr <= strobes.deliverCols && (|colDed);
      ackValid  <= strobes.deliverRows || (strobes.deliverCols && !(|colDed));
      nackValid <= strobes.raiseNack;
      if (strobes.deliverRows)      msgData <= rowMsg;
      else if (strobes.deliverCols) msgData <= colMsg;
    end
  end

endmodule

// File: rtl/pc_harq_rx.sv
module pc_harq_rx
  import pc_harq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int ROW_DATA = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int ROW_CODE = ROW_DATA + parBits(ROW_DATA) + 1,
  localparam int MSG_W = ROWS * ROW_DATA,
  localparam int LINK_W = ROWS * ROW_CODE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkValid,
  input  logic              linkPhase,
  input  logic [LINK_W-1:0] linkWord,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgData,
  output logic              msgUncorr,
  output logic              ackValid,
  output logic              nackValid
);

  rxStrobes_t strobes;
  logic       anyRowDed;

  pc_harq_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkValid(linkValid),
    .linkPhase(linkPhase),
    .anyRowDed(anyRowDed),
    .strobes  (strobes)
  );

  pc_harq_dp #(.ROWS(ROWS), .ROW_DATA(ROW_DATA)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .linkWord (linkWord),
    .strobes  (strobes),
    .anyRowDed(anyRowDed),
    .msgValid (msgValid),
    .msgData  (msgData),
    .msgUncorr(msgUncorr),
    .ackValid (ackValid),
    .nackValid(nackValid)
  );

endmodule

// File: rtl/pc_harq_checker.sv
module pc_harq_checker (
  input logic clk,
  input logic rstN,
  input logic linkValid,
  input logic msgValid,
  input logic msgUncorr,
  input logic ackValid,
  input logic nackValid
);

  assert_ack_nack_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ackValid && nackValid));

  assert_msg_after_link_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(linkValid));

  assert_uncorr_no_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgUncorr |-> (msgValid && !ackValid));

  assert_ack_has_msg_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> msgValid);

  assert_nack_no_msg_R3: assert property (@(posedge clk) disable iff (!rstN)
    nackValid |-> !msgValid);

endmodule

bind pc_harq_rx pc_harq_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .linkValid(linkValid),
  .msgValid (msgValid),
  .msgUncorr(msgUncorr),
  .ackValid (ackValid),
  .nackValid(nackValid)
);

// File: tb/sim_pc_harq_rx.sv
module sim_pc_harq_rx;

  localparam int TOUT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkValid = 1'b0;
  logic        linkPhase = 1'b0;
  logic [51:0] linkWord = '0;
  logic        msgValid;
  logic [31:0] msgData;
  logic        msgUncorr;
  logic        ackValid;
  logic        nackValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pc_harq_rx u0 (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .linkPhase(linkPhase),
    .linkWord(linkWord), .msgValid(msgValid), .msgData(msgData),
    .msgUncorr(msgUncorr), .ackValid(ackValid), .nackValid(nackValid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Extended Hamming encoder: overall parity bit 0, checks at powers of two.
  function automatic logic [12:0] encHam(input logic [7:0] d, input int k);
    logic [12:0] c;
    int pc;
    int idx;
    pc = (k == 8) ? 4 : 3;
    c = '0;
    idx = 0;
    for (int pos = 1; pos <= k + pc; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[idx];
        idx++;
      end
    end
    for (int b = 0; b < pc; b++) begin
      logic par;
      par = 1'b0;
      for (int pos = 1; pos <= k + pc; pos++)
        if ((pos & (1 << b)) != 0) par ^= c[pos];
      c[1 << b] = par;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [51:0] buildFirst(input logic [31:0] m);
    logic [51:0] w;
    for (int r = 0; r < 4; r++) w[r*13 +: 13] = encHam(m[r*8 +: 8], 8);
    return w;
  endfunction

  function automatic logic [51:0] buildSecond(input logic [31:0] m);
    logic [7:0] chk [4];
    logic [51:0] w;
    int cpos [4];
    cpos[0] = 0; cpos[1] = 1; cpos[2] = 2; cpos[3] = 4;
    for (int j = 0; j < 8; j++) begin
      logic [7:0] cd;
      logic [12:0] cc;
      cd = '0;
      for (int r = 0; r < 4; r++) cd[r] = m[r*8 + j];
      cc = encHam(cd, 4);
      for (int q = 0; q < 4; q++) chk[q][j] = cc[cpos[q]];
    end
    for (int q = 0; q < 4; q++) w[q*13 +: 13] = encHam(chk[q], 8);
    return w;
  endfunction

  task automatic sendWord(input logic ph, input logic [51:0] w);
    @(negedge clk);
    linkValid = 1'b1;
    linkPhase = ph;
    linkWord  = w;
    @(negedge clk);
    linkValid = 1'b0;
  endtask

  task automatic runCase(input logic [31:0] m, input logic [51:0] err, input bit expNack, input string tag);
    sendWord(1'b0, buildFirst(m) ^ err);
    if (expNack) begin
      check(nackValid && !msgValid && !ackValid, {tag, " R3 nack"}, {nackValid, msgValid, ackValid}, 3'b100);
      sendWord(1'b1, buildSecond(m));
      check(msgValid && ackValid && !msgUncorr && msgData == m, {tag, " R5 col fix"}, {msgValid, ackValid, msgUncorr, msgData}, {3'b110, m});
    end else begin
      check(msgValid && ackValid && !nackValid && msgData == m, {tag, " R2 row fix"}, {msgValid, ackValid, nackValid, msgData}, {3'b110, m});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] msgs [4];
    logic [31:0] lcg;
    int k;
    msgs[0] = 32'h0000_0000; msgs[1] = 32'hFFFF_FFFF;
    msgs[2] = 32'hA5C3_3C5A; msgs[3] = 32'h1357_9BDF;

    // R8-style reset view (R10 reset clause)
    repeat (3) @(negedge clk);
    check(!msgValid && !ackValid && !nackValid && !msgUncorr && msgData == 0, "R10 reset",
          {msgValid, ackValid, nackValid, msgUncorr, msgData}, 0);
    rstN = 1'b1;

    // R9 bit mapping
    runCase(32'h0000_0100, '0, 1'b0, "R9 row1 bit0");
    check(msgData[8] == 1'b1, "R9 map", msgData, 32'h100);

    // R1/R2 single error sweep
    for (int mi = 0; mi < 4; mi++)
      for (int p = 0; p < 52; p++)
        runCase(msgs[mi], 52'b1 << p, 1'b0, "R1 single");

    // R6/R4 all double errors
    lcg = 32'h1234_5678;
    for (int a = 0; a < 52; a++) begin
      for (int b = a + 1; b < 52; b++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        runCase(lcg, (52'b1 << a) | (52'b1 << b), (a / 13) == (b / 13), "R6 R4 double");
      end
    end

    // R3 pulse width
    sendWord(1'b0, buildFirst(msgs[2]) ^ 52'h3);
    check(nackValid == 1'b1, "R3 nack high", nackValid, 1);
    @(negedge clk);
    check(nackValid == 1'b0, "R3 nack one cycle", nackValid, 0);
    sendWord(1'b1, buildSecond(msgs[2]));
    check(msgValid && msgData == msgs[2], "R4 after pulse", msgData, msgs[2]);

    // R5 column double error -> uncorrectable flag
    sendWord(1'b0, buildFirst(msgs[3]) ^ ((52'b1 << 3) | (52'b1 << 5) | (52'b1 << 16) | (52'b1 << 18)));
    check(nackValid == 1'b1, "R5 nack", nackValid, 1);
    sendWord(1'b1, buildSecond(msgs[3]));
    check(msgValid && msgUncorr && !ackValid, "R5 uncorr", {msgValid, msgUncorr, ackValid}, 3'b110);

    // R7 timeout spacing
    sendWord(1'b0, buildFirst(msgs[1]) ^ 52'h6);
    check(nackValid == 1'b1, "R7 first nack", nackValid, 1);
    for (int rep = 0; rep < 2; rep++) begin
      k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!nackValid && k < 100);
      check(k == TOUT, "R7 nack period", k, TOUT);
    end
    sendWord(1'b1, buildSecond(msgs[1]));
    check(msgValid && ackValid && msgData == msgs[1], "R7 recover", msgData, msgs[1]);

    // R8 second-phase word while idle is ignored
    sendWord(1'b1, buildSecond(msgs[2]));
    check(!msgValid && !ackValid && !nackValid, "R8 idle phase1", {msgValid, ackValid, nackValid}, 0);

    // R8 first-phase word while waiting is ignored, held data kept
    sendWord(1'b0, buildFirst(msgs[2]) ^ 52'h18);
    check(nackValid == 1'b1, "R8 enter wait", nackValid, 1);
    sendWord(1'b0, buildFirst(msgs[3]));
    check(!msgValid && !ackValid && !nackValid, "R8 wait phase0", {msgValid, ackValid, nackValid}, 0);
    sendWord(1'b1, buildSecond(msgs[2]));
    check(msgValid && ackValid && msgData == msgs[2], "R8 held kept", msgData, msgs[2]);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule